// File: doc/BRIEF.md
# Sparse-Tap Reloadable Channel FIR

This block reproduces one single-input single-output fading path in the time domain. The impulse response it models can be up to `LINE_LEN` sample periods long, but only a few paths carry energy. A long shift register keeps the recent input samples. A small bank of multipliers is laid over it, and each multiplier picks its own sample from the register through a programmable position. As a result, `NTAPS` multipliers can serve any sparse profile whose delays fall inside the line.

A profile is a gain and a delay for every multiplier. Software writes the next profile into a shadow copy through a simple address/data/write-enable port while the active profile keeps filtering. When the refresh strobe is high, the whole shadow profile becomes active on that clock edge. Each output sample is the full-precision sum of the products, registered two stages after the input sample that reaches it with zero delay.

Top module: `sparse_chan_fir`

## Requirements
- R1: After a synchronous active-low reset, the active and shadow profiles, the delay line and the pipeline are all zero, so `y_out` reads 0.
- R2: Suppose tap k is active with position p and coefficient c. The input sampled at clock edge t then adds c times that input to the output that is registered at edge t+p+2. Position 0 therefore gives a two-cycle latency.
- R3: A tap whose active coefficient is zero adds nothing, whatever its position. This lets profiles with fewer than `NTAPS` paths run unchanged.
- R4: A write to the shadow profile has no effect on `y_out` until a refresh copies it into the active profile.
- R5: `y_out` is the exact sum over all `NTAPS` taps of coefficient times delayed input, with both operands taken as two's complement (14-bit input, 16-bit coefficient by default).
- R6: The output is `SAMP_W+COEF_W+ceil(log2(NTAPS))` bits wide (35 by default). It gives the exact result even when every tap sees full-scale inputs and full-scale coefficients of either sign.
- R7: When `refresh` is high at an edge, every coefficient and position is copied from shadow to active at that same edge. A shadow write in the same cycle lands in the shadow profile only, after the copy. Every output sample is computed from a single profile.
- R8: Write address encoding: bit [5] selects the field (0 = coefficient, 1 = position), and bits [4:0] give the tap index. A position takes `wr_data[7:0]`. A write with a tap index of `NTAPS` (18) or more changes nothing.
- R9: A tap whose position is `LINE_LEN` (131) or more adds nothing to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in | input | 14 | Signed input sample |
| wr_en | input | 1 | Shadow profile write strobe |
| wr_addr | input | 6 | Field select [5] and tap index [4:0] |
| wr_data | input | 16 | Coefficient, or position in bits [7:0] |
| refresh | input | 1 | Copy the shadow profile into the active profile at this edge |
| y_out | output | 35 | Signed filtered output sample |

## Verification
The hardest case to set up from the ports is a profile swap that lands while samples are still in flight through the pipeline, together with a shadow write in the same cycle. An error there only shows as an output that mixes two profiles for a single sample. The bench streams pseudo-random input without a break. It issues refreshes in the same cycle as writes, and back to back. It models the swap at the exact edge, so any sample built from the wrong profile differs from the expected sum. The bench also sweeps one tap through every one of the 131 positions, with an impulse each time, so each delay and each latency is checked on its own.

// File: rtl/sfir_pkg.sv
// Package: shared widths and field codes for the sparse-tap channel FIR.
// Assumes tap counts of at least one.
package sfir_pkg;
    // Field select carried in the top bit of the shadow write address.
    typedef enum logic {
        FLD_COEF = 1'b0,
        FLD_POS  = 1'b1
    } sfir_field_e;

    // Bits needed to index a tap.
    function automatic int tap_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Write address: tap index plus one field-select bit.
    function automatic int addr_w(input int n);
        return tap_idx_w(n) + 1;
    endfunction

    // Accumulator width that cannot overflow for n signed products.
    function automatic int acc_w(input int s, input int c, input int n);
        return s + c + tap_idx_w(n);
    endfunction
endpackage

// File: rtl/sfir_delay_line.sv
// Module: input sample delay line.
// Entry 0 holds the newest sample after each edge, and entry k holds the
// sample from k edges earlier. Assumes one sample per clock.
module sfir_delay_line #(
    parameter int SAMP_W   = 14,
    parameter int LINE_LEN = 131
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SAMP_W-1:0]                x_in,
    output logic [LINE_LEN-1:0][SAMP_W-1:0]  line
);
    // Shift every sample one place further per clock, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
        end else begin
            line[0] <= x_in;
            for (int i = 1; i < LINE_LEN; i++) begin
                line[i] <= line[i-1];
            end
        end
    end
endmodule

// File: rtl/sfir_profile_bank.sv
// Module: double-buffered tap profile (coefficients and positions).
// The shadow copy is written one field per cycle. On refresh, the whole
// shadow copy moves to the active copy at that edge. A write in the same
// cycle updates only the shadow copy. Out-of-range tap indices are dropped.
module sfir_profile_bank #(
    parameter int NTAPS  = 18,
    parameter int COEF_W = 16,
    parameter int POS_W  = 8,
    parameter int AW     = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [AW-1:0]                    wr_addr,
    input  logic [COEF_W-1:0]                wr_data,
    input  logic                             refresh,
    output logic [NTAPS-1:0][COEF_W-1:0]     shd_coef,
    output logic [NTAPS-1:0][POS_W-1:0]      shd_pos,
    output logic [NTAPS-1:0][COEF_W-1:0]     act_coef,
    output logic [NTAPS-1:0][POS_W-1:0]      act_pos
);
    import sfir_pkg::*;

    localparam int IDX_W = AW - 1;

    logic [IDX_W-1:0] wr_idx;
    sfir_field_e      wr_fld;
    logic             wr_hit;

    // Split the write address into tap index and field, and range-check it.
    always_comb begin
        wr_idx = wr_addr[IDX_W-1:0];
        wr_fld = sfir_field_e'(wr_addr[AW-1]);
        wr_hit = wr_en && (32'(wr_idx) < NTAPS);
    end

    // Shadow profile: one coefficient or position per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_coef <= '0;
            shd_pos  <= '0;
        end else if (wr_hit) begin
            if (wr_fld == FLD_POS) begin
                shd_pos[wr_idx] <= wr_data[POS_W-1:0];
            end else begin
                shd_coef[wr_idx] <= wr_data;
            end
        end
    end

    // Active profile: whole-profile copy on the refresh strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_coef <= '0;
            act_pos  <= '0;
        end else if (refresh) begin
            act_coef <= shd_coef;
            act_pos  <= shd_pos;
        end
    end
endmodule

// File: rtl/sfir_tap_mult.sv
// Module: one multiplier with a programmable delay.
// Takes the delay line sample at the given position, or zero if the
// position lies past the line, and registers its product with the coefficient.
module sfir_tap_mult #(
    parameter int SAMP_W   = 14,
    parameter int COEF_W   = 16,
    parameter int LINE_LEN = 131,
    parameter int POS_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LINE_LEN-1:0][SAMP_W-1:0]    line,
    input  logic [POS_W-1:0]                   pos,
    input  logic [COEF_W-1:0]                  coef,
    output logic signed [SAMP_W+COEF_W-1:0]    prod
);
    logic signed [SAMP_W-1:0] sel;

    // Position multiplexer with a zero fill for positions past the line.
    always_comb begin
        sel = '0;
        for (int i = 0; i < LINE_LEN; i++) begin
            if (32'(pos) == i) begin
                sel = line[i];
            end
        end
    end

    // Registered signed product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else begin
            prod <= sel * $signed(coef);
        end
    end
endmodule

// File: rtl/sfir_adder_tree.sv
// Module: registered full-precision binary adder tree.
// Sign-extends N products to OUT_W and pads the tree to a power of two
// with zeros. Assumes OUT_W is at least IN_W + ceil(log2(N)).
module sfir_adder_tree #(
    parameter int N     = 18,
    parameter int IN_W  = 30,
    parameter int OUT_W = 35
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W-1:0]   prod [N],
    output logic signed [OUT_W-1:0]  sum
);
    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
    localparam int LEAVES = 1 << LEVELS;

    logic signed [OUT_W-1:0] node [LEVELS+1][LEAVES];

    // Pairwise reduction, one tree level per outer iteration.
    always_comb begin
        for (int l = 0; l <= LEVELS; l++) begin
            for (int i = 0; i < LEAVES; i++) begin
                node[l][i] = '0;
            end
        end
        for (int i = 0; i < N; i++) begin
            node[0][i] = OUT_W'(prod[i]);
        end
        for (int l = 1; l <= LEVELS; l++) begin
            for (int i = 0; i < (LEAVES >> l); i++) begin
                node[l][i] = node[l-1][2*i] + node[l-1][2*i+1];
            end
        end
    end

    // Output register for the tree root.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else begin
            sum <= node[LEVELS][0];
        end
    end
endmodule

// File: rtl/sparse_chan_fir.sv
// Module: sparse-tap reloadable channel FIR (top).
// NTAPS multipliers each read one programmable position of a LINE_LEN
// sample delay line. Their products are summed at full precision. The
// gain/position profile is double-buffered and swapped on refresh.
// Latency is two cycles from the input edge for position 0.
// Assumes COEF_W >= ceil(log2(LINE_LEN)).
module sparse_chan_fir #(
    parameter int SAMP_W   = 14,
    parameter int COEF_W   = 16,
    parameter int NTAPS    = 18,
    parameter int LINE_LEN = 131
) (
    input  logic                                                    clk,
    input  logic                                                    rst_n,
    input  logic [SAMP_W-1:0]                                       x_in,
    input  logic                                                    wr_en,
    input  logic [sfir_pkg::addr_w(NTAPS)-1:0]                      wr_addr,
    input  logic [COEF_W-1:0]                                       wr_data,
    input  logic                                                    refresh,
    output logic signed [sfir_pkg::acc_w(SAMP_W,COEF_W,NTAPS)-1:0]  y_out
);
    localparam int POS_W  = $clog2(LINE_LEN);
    localparam int AW     = sfir_pkg::addr_w(NTAPS);
    localparam int PROD_W = SAMP_W + COEF_W;
    localparam int OUT_W  = sfir_pkg::acc_w(SAMP_W, COEF_W, NTAPS);

    logic [LINE_LEN-1:0][SAMP_W-1:0] line;
    logic [NTAPS-1:0][COEF_W-1:0]    shd_coef;
    logic [NTAPS-1:0][POS_W-1:0]     shd_pos;
    logic [NTAPS-1:0][COEF_W-1:0]    act_coef;
    logic [NTAPS-1:0][POS_W-1:0]     act_pos;
    logic signed [PROD_W-1:0]        prod [NTAPS];

    sfir_delay_line #(.SAMP_W(SAMP_W), .LINE_LEN(LINE_LEN)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .line  (line)
    );

    sfir_profile_bank #(
        .NTAPS(NTAPS), .COEF_W(COEF_W), .POS_W(POS_W), .AW(AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .refresh  (refresh),
        .shd_coef (shd_coef),
        .shd_pos  (shd_pos),
        .act_coef (act_coef),
        .act_pos  (act_pos)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        sfir_tap_mult #(
            .SAMP_W(SAMP_W), .COEF_W(COEF_W), .LINE_LEN(LINE_LEN), .POS_W(POS_W)
        ) u_mult (
            .clk   (clk),
            .rst_n (rst_n),
            .line  (line),
            .pos   (act_pos[k]),
            .coef  (act_coef[k]),
            .prod  (prod[k])
        );
    end

    sfir_adder_tree #(.N(NTAPS), .IN_W(PROD_W), .OUT_W(OUT_W)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .prod  (prod),
        .sum   (y_out)
    );
endmodule

// File: rtl/sfir_checker.sv
// Module: protocol and profile-swap properties for sparse_chan_fir.
// Bound into the top module. It watches the ports and the profile bank
// outputs.
module sfir_checker #(
    parameter int NTAPS  = 18,
    parameter int COEF_W = 16,
    parameter int POS_W  = 8,
    parameter int AW     = 6,
    parameter int OUT_W  = 35
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [AW-1:0]             wr_addr,
    input logic                      refresh,
    input logic [OUT_W-1:0]          y_out,
    input logic [NTAPS*COEF_W-1:0]   shd_coef,
    input logic [NTAPS*POS_W-1:0]    shd_pos,
    input logic [NTAPS*COEF_W-1:0]   act_coef,
    input logic [NTAPS*POS_W-1:0]    act_pos
);
    AST_HOLD_WITHOUT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> ($stable(act_coef) && $stable(act_pos))); // R4

    AST_SWAP_WHOLE_PROFILE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (act_coef == $past(shd_coef) && act_pos == $past(shd_pos))); // R7

    AST_ZERO_GAINS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_coef == '0) |-> ##2 (y_out == '0)); // R3

    AST_BAD_INDEX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_addr[AW-2:0]) >= NTAPS)) |=> ($stable(shd_coef) && $stable(shd_pos))); // R8
endmodule

bind sparse_chan_fir sfir_checker #(
    .NTAPS(NTAPS), .COEF_W(COEF_W), .POS_W(POS_W), .AW(AW), .OUT_W(OUT_W)
) u_sfir_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .refresh  (refresh),
    .y_out    (y_out),
    .shd_coef (shd_coef),
    .shd_pos  (shd_pos),
    .act_coef (act_coef),
    .act_pos  (act_pos)
);

// File: tb/test_sparse_chan_fir.sv
// Bench: self-checking sweeps of sparse_chan_fir against a cycle model
// that works from the requirements. The output is compared every cycle.
module test_sparse_chan_fir;
    localparam int NT   = 18;
    localparam int LEN  = 131;
    localparam int AWB  = 6;
    localparam int OW   = 35;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [13:0]           x_in = '0;
    logic                  wr_en = 1'b0;
    logic [AWB-1:0]        wr_addr = '0;
    logic [15:0]           wr_data = '0;
    logic                  refresh = 1'b0;
    logic signed [OW-1:0]  y_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Model state
    longint xh [256];
    int     e = 0;
    longint m_sc [NT];
    int     m_sp [NT];
    longint m_ac [NT];
    int     m_ap [NT];
    longint pipe0 = 0;
    longint pipe1 = 0;
    logic [15:0] lfsr = 16'hACE1;

    sparse_chan_fir i_sparse_chan_fir (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .refresh(refresh), .y_out(y_out)
    );

    always #10 clk = ~clk;

    function automatic longint model_sum();
        longint s = 0;
        for (int k = 0; k < NT; k++) begin
            if (m_ap[k] < LEN && e - m_ap[k] >= 0) begin
                s += m_ac[k] * xh[(e - m_ap[k]) & 255];
            end
        end
        return s;
    endfunction

    function automatic longint next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return longint'($signed(lfsr[13:0]));
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, e, act, exp);
        end
    endtask

    // One sample cycle: drive at negedge, update the model at the edge,
    // then compare y_out away from the edge.
    task automatic step(input longint x, input bit we, input int addr,
                        input int data, input bit rf, input string tag);
        x_in    = 14'(x);
        wr_en   = we;
        wr_addr = AWB'(addr);
        wr_data = 16'(data);
        refresh = rf;
        @(posedge clk);
        if (rf) begin
            for (int k = 0; k < NT; k++) begin
                m_ac[k] = m_sc[k];
                m_ap[k] = m_sp[k];
            end
        end
        if (we && (addr % 32) < NT) begin
            if (addr >= 32) m_sp[addr % 32] = data & 255;
            else            m_sc[addr % 32] = longint'($signed(16'(data)));
        end
        e++;
        xh[e & 255] = longint'($signed(14'(x)));
        #5;
        check(tag, longint'(y_out), pipe1);
        pipe1 = pipe0;
        pipe0 = model_sum();
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data, input string tag);
        step(next_rand(), 1'b1, addr, data, 1'b0, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(next_rand(), 1'b0, 0, 0, 1'b0, tag);
    endtask

    task automatic swap(input string tag);
        step(next_rand(), 1'b0, 0, 0, 1'b1, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog R1: actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int pos_ex [NT];
        pos_ex = '{0, 2, 4, 5, 9, 14, 20, 25, 32, 41, 50, 59, 68, 77, 88, 101, 115, 130};
        for (int i = 0; i < 256; i++) xh[i] = 0;
        for (int k = 0; k < NT; k++) begin
            m_sc[k] = 0; m_sp[k] = 0; m_ac[k] = 0; m_ap[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset", longint'(y_out), 0);

        // R4: shadow writes without refresh leave output at zero
        for (int k = 0; k < NT; k++) begin
            wr(32 + k, pos_ex[k], "R4");
            wr(k, (k % 2 == 0) ? 20000 - k * 1100 : -(19000 - k * 900), "R4");
        end
        run(60, "R4");

        // R5: full example profile, random stream
        swap("R5");
        run(300, "R5");

        // R3: only three non-zero gains, other taps keep spread positions
        for (int k = 0; k < NT; k++) wr(k, 0, "R3");
        wr(3, 1234, "R3");
        wr(9, -31000, "R3");
        wr(17, 777, "R3");
        swap("R3");
        run(160, "R3");

        // R6: full-scale extremes of both signs
        for (int k = 0; k < NT; k++) begin
            wr(32 + k, k * 7, "R6");
            wr(k, -32768, "R6");
        end
        swap("R6");
        for (int i = 0; i < 140; i++) step(-8192, 1'b0, 0, 0, 1'b0, "R6");
        for (int k = 0; k < NT; k++) wr(k, 32767, "R6");
        swap("R6");
        for (int i = 0; i < 140; i++) step(-8192, 1'b0, 0, 0, 1'b0, "R6");
        for (int i = 0; i < 140; i++) step(8191, 1'b0, 0, 0, 1'b0, "R6");

        // R7: write in the refresh cycle, back-to-back refreshes mid-stream
        for (int k = 0; k < NT; k++) wr(32 + k, pos_ex[k], "R7");
        step(next_rand(), 1'b1, 4, 5555, 1'b1, "R7");
        run(10, "R7");
        step(next_rand(), 1'b1, 32 + 4, 3, 1'b1, "R7");
        step(next_rand(), 1'b1, 6, -4000, 1'b1, "R7");
        swap("R7");
        run(150, "R7");

        // R8: out-of-range tap indices are dropped
        wr(18, 9999, "R8");
        wr(31, -9999, "R8");
        wr(32 + 20, 1, "R8");
        wr(32 + 31, 1, "R8");
        swap("R8");
        run(150, "R8");

        // R9: positions at or past the line end contribute nothing
        wr(32 + 0, 131, "R9");
        wr(32 + 1, 200, "R9");
        wr(32 + 2, 255, "R9");
        wr(0, 30000, "R9");
        wr(1, -30000, "R9");
        wr(2, 12345, "R9");
        swap("R9");
        run(150, "R9");

        // R2: single tap swept over every position with an impulse
        for (int k = 0; k < NT; k++) step(0, 1'b1, k, 0, 1'b0, "R2");
        swap("R2");
        run(0, "R2");
        for (int i = 0; i < LEN + 3; i++) step(0, 1'b0, 0, 0, 1'b0, "R2");
        for (int p = 0; p < LEN; p++) begin
            int j = p % NT;
            if (p > 0) step(0, 1'b1, (p - 1) % NT, 0, 1'b0, "R2");
            step(0, 1'b1, 32 + j, p, 1'b0, "R2");
            step(0, 1'b1, j, (p - 65) * 37 + 11, 1'b0, "R2");
            step(0, 1'b0, 0, 0, 1'b1, "R2");
            step(5, 1'b0, 0, 0, 1'b0, "R2");
            for (int i = 0; i < p + 3; i++) step(0, 1'b0, 0, 0, 1'b0, "R2");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule